// File: doc/BRIEF.md
# Video Capture Window Controller

This block sits between a pixel digitizer and a linear frame buffer. It decides which digitized pixels fall inside a programmed capture rectangle, and it produces the word address at which each packed word is written. Horizontal and vertical sync pulses, a field identity flag and a per-pixel valid signal all arrive in the pixel clock domain. The block counts pixels along each line and lines within each field. It raises a store enable only for pixels inside the rectangle while a grab is running.

Software sets the rectangle origin and size, a base word address, one of four grab modes and a continuous/single flag, then pulses `arm`. The controller waits for a vertical sync that opens a suitable field and then captures. The external packer reports each finished 32-bit word on `word_stb`. The controller turns that strobe into a write enable and steps a word address that runs on without gaps across line and field boundaries, wrapping at the top of memory. A single grab ends at a field or frame boundary with a one-cycle `done` pulse. A continuous grab keeps filling successive memory until a stop request, and then it ends at the next boundary.

Top module: `capwin_ctrl`

## Requirements
- R1: The pixel index is the number of accepted pixels since the last `hsync` or `vsync`, starting at 0 and saturating at its maximum. The line index is 0 on the first line after `vsync` and steps by one on each `hsync`; it is all-ones between `vsync` and the first `hsync`. A pixel is stored (`store_en`=1) only if `win_x` <= pixel index < `win_x`+`win_w` and `win_y` <= line index < `win_y`+`win_h`.
- R2: `store_en` is high only while a capture is running, and it is never high in a cycle with `hsync` or `vsync` high. `pix_valid` is ignored in those sync cycles and does not advance the pixel index.
- R3: When an arm is accepted, `wr_addr` loads `base_addr`. While a capture is running, each `word_stb` gives `wr_en`=1 for that cycle and raises `wr_addr` by one in the next cycle, modulo 2^AW. The address is never reset between lines or between fields of one grab.
- R4: `grab_mode` 0 captures one field that opens with `field_odd`=0 at `vsync`. Mode 1 captures one field that opens with `field_odd`=1. Mode 2 captures two consecutive fields starting at a field with `field_odd`=0. Mode 3 captures one vertical period starting at any `vsync`.
- R5: After an arm, nothing is stored and no word is written until a `vsync` that opens a unit of the selected mode. The capture runs from the cycle after that `vsync`.
- R6: With `continuous`=0, the `vsync` that closes the unit ends the grab. In the next cycle `done` is 1 for exactly one cycle and the controller is idle.
- R7: With `continuous`=1, the controller moves straight to the next qualifying unit and keeps the running address. A `stop_req` during a capture makes the grab end at the close of the current unit, with the same `done` pulse as R6.
- R8: `busy` rises in the cycle after an accepted `arm` and stays high until the grab ends. `busy` is 0 in the cycle where `done` is 1.
- R9: `arm` has no effect while `busy` is 1. A `stop_req` while waiting for the first unit returns the controller to idle with no `done` pulse.
- R10: During and right after reset, `store_en`, `wr_en`, `busy` and `done` are 0 and `wr_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | One-cycle line start pulse |
| vsync | input | 1 | One-cycle field start pulse |
| field_odd | input | 1 | Field identity, sampled with `vsync` |
| pix_valid | input | 1 | A digitized pixel is present |
| word_stb | input | 1 | Packer finished a word this cycle |
| win_x | input | XW | Window first pixel index |
| win_y | input | YW | Window first line index |
| win_w | input | XW | Window width in pixels |
| win_h | input | YW | Window height in lines |
| base_addr | input | AW | First word address of a grab |
| grab_mode | input | 2 | 0 even field, 1 odd field, 2 interlaced frame, 3 progressive |
| continuous | input | 1 | 1 keeps grabbing until stopped |
| arm | input | 1 | Start a grab (ignored while busy) |
| stop_req | input | 1 | End a grab at the next boundary |
| store_en | output | 1 | Current pixel lies inside the window |
| wr_en | output | 1 | Write the packed word at `wr_addr` |
| wr_addr | output | AW | Word write address |
| busy | output | 1 | A grab is armed or running |
| done | output | 1 | One-cycle grab completion pulse |

## Verification
The bench builds the controller with XW=6, YW=5 and AW=6. A 64-word address space means one continuous grab of a few fields runs past the top of memory and shows the modulo wrap. With six-bit pixel counters, a 12-pixel line with a window from 3 to 7 puts both window edges, and the pixels just outside them, into every line. The five-bit line index keeps the all-ones value before the first line visibly outside a window that starts at line 2.

// File: rtl/capwin_pkg.sv
package capwin_pkg;

  typedef enum logic [1:0] {
    GRAB_EVEN  = 2'd0,
    GRAB_ODD   = 2'd1,
    GRAB_FRAME = 2'd2,
    GRAB_PROG  = 2'd3
  } grab_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAP  = 2'd2
  } seq_st_e;

  // Half-open span test [start, start+len); counters up to 16 bits wide.
  function automatic logic in_span(input logic [15:0] pos,
                                   input logic [15:0] start,
                                   input logic [15:0] len);
    logic [16:0] lim;
    lim = {1'b0, start} + {1'b0, len};
    return ({1'b0, pos} >= {1'b0, start}) && ({1'b0, pos} < lim);
  endfunction

  // Does a vertical sync with this field identity open a capture unit?
  function automatic logic opens_unit(input grab_mode_e m, input logic odd);
    case (m)
      GRAB_EVEN:  return !odd;
      GRAB_ODD:   return odd;
      GRAB_FRAME: return !odd;
      default:    return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/capwin_scan.sv
module capwin_scan #(
  parameter int XW = 12,
  parameter int YW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync,
  input  logic          vsync,
  input  logic          pix_valid,
  output logic [XW-1:0] xcnt,
  output logic [YW-1:0] ycnt,
  output logic          pix_live
);

  assign pix_live = pix_valid && !hsync && !vsync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xcnt <= '0;
      ycnt <= '1;
    end else begin
      if (hsync || vsync)
        xcnt <= '0;
      else if (pix_live && (xcnt != '1))
        xcnt <= xcnt + 1'b1;

      if (vsync)
        ycnt <= '1;
      else if (hsync)
        ycnt <= ycnt + 1'b1;
    end
  end

endmodule

// File: rtl/capwin_seq.sv
module capwin_seq
  import capwin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vsync,
  input  logic       field_odd,
  input  grab_mode_e mode,
  input  logic       continuous,
  input  logic       arm,
  input  logic       stop_req,
  output logic       capturing,
  output logic       busy,
  output logic       done,
  output logic       arm_take,
  output logic       unit_end
);

  seq_st_e st;
  logic    second_fld;
  logic    stop_pend;
  logic    opens;
  logic    stop_eff;
  logic    mid_frame;

  assign opens     = opens_unit(mode, field_odd);
  assign capturing = (st == ST_CAP);
  assign busy      = (st != ST_IDLE);
  assign arm_take  = arm && (st == ST_IDLE);
  assign mid_frame = (mode == GRAB_FRAME) && !second_fld;
  assign unit_end  = capturing && vsync && !mid_frame;
  assign stop_eff  = stop_pend || stop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      second_fld <= 1'b0;
      stop_pend  <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          stop_pend <= 1'b0;
          if (arm) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (stop_req) begin
            st <= ST_IDLE;
          end else if (vsync && opens) begin
            st         <= ST_CAP;
            second_fld <= 1'b0;
          end
        end
        ST_CAP: begin
          if (vsync && mid_frame) begin
            second_fld <= 1'b1;
            stop_pend  <= stop_eff;
          end else if (unit_end) begin
            if (continuous && !stop_eff) begin
              st         <= opens ? ST_CAP : ST_WAIT;
              second_fld <= 1'b0;
            end else begin
              st        <= ST_IDLE;
              done      <= 1'b1;
              stop_pend <= 1'b0;
            end
          end else begin
            stop_pend <= stop_eff;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/capwin_addr.sv
module capwin_addr #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          step,
  output logic [AW-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr <= '0;
    else if (load)
      addr <= base;
    else if (step)
      addr <= addr + 1'b1;
  end

endmodule

// File: rtl/capwin_ctrl.sv
module capwin_ctrl
  import capwin_pkg::*;
#(
  parameter int XW = 12,
  parameter int YW = 11,
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync,
  input  logic          vsync,
  input  logic          field_odd,
  input  logic          pix_valid,
  input  logic          word_stb,
  input  logic [XW-1:0] win_x,
  input  logic [YW-1:0] win_y,
  input  logic [XW-1:0] win_w,
  input  logic [YW-1:0] win_h,
  input  logic [AW-1:0] base_addr,
  input  logic [1:0]    grab_mode,
  input  logic          continuous,
  input  logic          arm,
  input  logic          stop_req,
  output logic          store_en,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          busy,
  output logic          done
);

  logic [XW-1:0] xcnt;
  logic [YW-1:0] ycnt;
  logic          pix_live;
  logic          capturing;
  logic          arm_take;
  logic          unit_end;
  logic          in_x;
  logic          in_y;

  capwin_scan #(.XW(XW), .YW(YW)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync     (hsync),
    .vsync     (vsync),
    .pix_valid (pix_valid),
    .xcnt      (xcnt),
    .ycnt      (ycnt),
    .pix_live  (pix_live)
  );

  capwin_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .vsync      (vsync),
    .field_odd  (field_odd),
    .mode       (grab_mode_e'(grab_mode)),
    .continuous (continuous),
    .arm        (arm),
    .stop_req   (stop_req),
    .capturing  (capturing),
    .busy       (busy),
    .done       (done),
    .arm_take   (arm_take),
    .unit_end   (unit_end)
  );

  assign in_x     = in_span(16'(xcnt), 16'(win_x), 16'(win_w));
  assign in_y     = in_span(16'(ycnt), 16'(win_y), 16'(win_h));
  assign store_en = capturing && pix_live && in_x && in_y;
  assign wr_en    = capturing && word_stb;

  capwin_addr #(.AW(AW)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (arm_take),
    .base  (base_addr),
    .step  (wr_en),
    .addr  (wr_addr)
  );

endmodule

// File: rtl/capwin_ctrl_chk.sv
module capwin_ctrl_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsync,
  input logic          vsync,
  input logic          arm,
  input logic [AW-1:0] base_addr,
  input logic          continuous,
  input logic          store_en,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          busy,
  input logic          done,
  input logic          capturing,
  input logic          unit_end
);

  p_store_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |-> capturing);

  p_sync_nostore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync || vsync) |-> !store_en);

  p_wait_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !capturing) |-> (!store_en && !wr_en));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_addr == AW'($past(wr_addr) + 1'b1)));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(arm && !busy)) |=> $stable(wr_addr));

  p_arm_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !busy) |=> (busy && wr_addr == $past(base_addr)));

  p_single_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_end && !continuous) |=> (done && !busy));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind capwin_ctrl capwin_ctrl_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hsync      (hsync),
  .vsync      (vsync),
  .arm        (arm),
  .base_addr  (base_addr),
  .continuous (continuous),
  .store_en   (store_en),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .busy       (busy),
  .done       (done),
  .capturing  (capturing),
  .unit_end   (unit_end)
);

// File: tb/capwin_ctrl_tb.sv
module capwin_ctrl_tb_top;

  localparam int XW = 6;
  localparam int YW = 5;
  localparam int AW = 6;
  localparam int MEM = 1 << AW;
  localparam int XMAX = (1 << XW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 0, vsync = 0, field_odd = 0, pix_valid = 0, word_stb = 0;
  logic [XW-1:0] win_x = 6'd3, win_w = 6'd5;
  logic [YW-1:0] win_y = 5'd2, win_h = 5'd3;
  logic [AW-1:0] base_addr = '0;
  logic [1:0] grab_mode = 2'd0;
  logic continuous = 0, arm = 0, stop_req = 0;
  logic store_en, wr_en, busy, done;
  logic [AW-1:0] wr_addr;

  always #2 clk = ~clk;

  capwin_ctrl #(.XW(XW), .YW(YW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .field_odd(field_odd), .pix_valid(pix_valid), .word_stb(word_stb),
    .win_x(win_x), .win_y(win_y), .win_w(win_w), .win_h(win_h),
    .base_addr(base_addr), .grab_mode(grab_mode), .continuous(continuous),
    .arm(arm), .stop_req(stop_req), .store_en(store_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .busy(busy), .done(done)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int n_store = 0;
  int n_done = 0;

  // Behavioural reference: 0 idle, 1 waiting, 2 capturing.
  int m_st = 0, m_x = 0, m_y = -1, m_addr = 0;
  bit m_second = 0, m_pend = 0, m_done = 0;

  function automatic bit qualifies(int mode, bit odd);
    if (mode == 3) return 1;
    if (mode == 1) return odd;
    return !odd;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_x = 0; m_y = -1; m_addr = 0;
      m_second = 0; m_pend = 0; m_done = 0;
    end else begin
      bit ends;
      bit stop_now;
      ends = 0;
      stop_now = m_pend || stop_req;
      m_done = 0;
      if (m_st == 0 && arm) m_addr = base_addr;
      else if (m_st == 2 && word_stb) m_addr = (m_addr + 1) % MEM;
      case (m_st)
        0: begin m_pend = 0; if (arm) m_st = 1; end
        1: begin
          if (stop_req) m_st = 0;
          else if (vsync && qualifies(grab_mode, field_odd)) begin
            m_st = 2; m_second = 0;
          end
        end
        default: begin
          if (vsync) begin
            if (grab_mode == 2 && !m_second) begin
              m_second = 1; m_pend = stop_now;
            end else ends = 1;
          end else m_pend = stop_now;
          if (ends) begin
            if (continuous && !stop_now) begin
              m_st = qualifies(grab_mode, field_odd) ? 2 : 1;
              m_second = 0;
            end else begin
              m_st = 0; m_done = 1; m_pend = 0;
            end
          end
        end
      endcase
      if (hsync || vsync) m_x = 0;
      else if (pix_valid && m_x < XMAX) m_x++;
      if (vsync) m_y = -1;
      else if (hsync) m_y++;
    end
  end

  // Compare every cycle, half a period after the edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_store;
      exp_store = pix_valid && !hsync && !vsync && (m_st == 2)
               && m_x >= win_x && m_x < win_x + win_w
               && m_y >= win_y && m_y < win_y + win_h;
      check(store_en == exp_store, "R1 store_en", store_en, exp_store);
      check(wr_en == (word_stb && m_st == 2), "R3 wr_en", wr_en, word_stb && m_st == 2);
      check(wr_addr == m_addr, "R3 wr_addr", wr_addr, m_addr);
      check(busy == (m_st != 0), "R8 busy", busy, m_st != 0);
      check(done == m_done, "R6 done", done, m_done);
      if (store_en) n_store++;
      if (done) n_done++;
    end
  end

  task automatic step();
    @(posedge clk); #1;
    hsync = 0; vsync = 0; pix_valid = 0; word_stb = 0; arm = 0; stop_req = 0;
  endtask

  task automatic vpulse(bit odd);
    vsync = 1; field_odd = odd; step();
  endtask

  task automatic line();
    hsync = 1; step();
    for (int p = 0; p < 12; p++) begin
      pix_valid = 1; word_stb = (p % 4 == 3); step();
    end
    step();
  endtask

  task automatic field(bit odd);
    vpulse(odd); step(); step();
    for (int l = 0; l < 6; l++) line();
  endtask

  task automatic do_arm(int base);
    base_addr = AW'(base); arm = 1; step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!store_en && !wr_en && !busy && !done, "R10 outputs in reset", busy, 0);
    check(wr_addr == 0, "R10 addr in reset", wr_addr, 0);
    rst_n = 1; step();
    check(!busy && wr_addr == 0, "R10 after reset", wr_addr, 0);

    // Even field, single.
    grab_mode = 2'd0; continuous = 0;
    do_arm(10);
    n_store = 0; field(1);
    check(n_store == 0, "R5 nothing before qualifying field", n_store, 0);
    field(0);
    check(n_store == 15, "R4 even field stores", n_store, 15);
    n_done = 0; vpulse(1); step();
    check(n_done == 1 && !busy, "R6 single ends with done", n_done, 1);
    check(wr_addr == 28, "R3 contiguous words", wr_addr, 28);

    // Odd field, single.
    grab_mode = 2'd1;
    do_arm(0);
    n_store = 0; field(0);
    check(n_store == 0, "R5 even field skipped in odd mode", n_store, 0);
    field(1);
    check(n_store == 15, "R4 odd field stores", n_store, 15);
    n_done = 0; vpulse(0); step();
    check(n_done == 1 && wr_addr == 18, "R6 odd done", wr_addr, 18);

    // Interlaced frame, single.
    grab_mode = 2'd2;
    do_arm(20);
    n_store = 0; field(1);
    check(n_store == 0, "R4 frame waits for even field", n_store, 0);
    n_done = 0; field(0); field(1);
    check(busy && n_done == 0, "R4 frame spans two fields", n_done, 0);
    check(n_store == 30, "R4 frame stores", n_store, 30);
    vpulse(0); step();
    check(n_done == 1 && wr_addr == 56, "R6 frame done", wr_addr, 56);

    // Progressive continuous, ignored re-arm, stop, address wrap.
    grab_mode = 2'd3; continuous = 1;
    do_arm(50);
    n_store = 0; n_done = 0;
    vpulse(1); step();
    do_arm(5);
    for (int l = 0; l < 6; l++) line();
    vpulse(0); step(); step();
    for (int l = 0; l < 3; l++) line();
    stop_req = 1; step();
    for (int l = 0; l < 3; l++) line();
    check(busy && n_done == 0, "R7 stop waits for boundary", n_done, 0);
    field(1);
    check(n_store == 30, "R7 two units stored", n_store, 30);
    check(n_done == 1 && !busy, "R7 stop ends with done", n_done, 1);
    check(wr_addr == 22, "R9 arm ignored, R3 wrap", wr_addr, 22);

    // Stop while waiting.
    grab_mode = 2'd0; continuous = 0;
    do_arm(7);
    field(1);
    n_done = 0; n_store = 0;
    stop_req = 1; step();
    field(0);
    check(!busy && n_done == 0 && n_store == 0, "R9 stop in wait", n_done, 0);

    // Continuous even mode over two even fields.
    continuous = 1;
    do_arm(0);
    n_store = 0; n_done = 0;
    field(0); field(1);
    check(busy, "R7 continuous keeps busy", busy, 1);
    field(0);
    stop_req = 1; step();
    field(1);
    check(n_store == 30 && n_done == 1, "R7 continuous stores", n_store, 30);
    check(wr_addr == 36, "R7 address carried", wr_addr, 36);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule